// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

A presettable binary counter whose direction is chosen by which of two strobe inputs pulses. A rising edge on the up strobe adds one to the value, and a rising edge on the down strobe subtracts one. The strobe that is not in use rests high. Both strobes are brought into the system clock domain through a synchronizer and an edge detector. All state bits then change on one system clock edge, so the outputs never show intermediate values.

A synchronous clear forces the value to zero. An active-low load copies a parallel data word into the counter. Clear wins over load, and load wins over counting. The active-low carry output follows the synchronized up strobe while the counter sits at its maximum. The active-low borrow output follows the synchronized down strobe while the counter sits at zero. Identical stages therefore chain with no glue logic: carry drives the next stage's up strobe and borrow drives its down strobe. Loading a preset shortens the count cycle, so the block can act as a modulo-N divider.

Top module: `updown_strobe_counter`

## Requirements
- R1: A rising edge on `up_clk`, with `dn_clk` held high, increments `q` by one. The new value appears on the third system clock edge after the input changes. Counting up from the maximum (all ones) wraps to 0.
- R2: A rising edge on `dn_clk`, with `up_clk` held high, decrements `q` by one, with the same latency as R1. Counting down from 0 wraps to the maximum.
- R3: While `load_n` is sampled low and `clr` is low, `q` takes the value of `data_in` on the next clock edge, and count strobes have no effect.
- R4: While `clr` is sampled high, `q` becomes 0 on the next clock edge, whatever `load_n` and the count strobes are doing.
- R5: `carry_n` is low only while `q` is at its maximum and the synchronized `up_clk` is low. The synchronized level lags the input by two clock edges. Otherwise `carry_n` is high.
- R6: `borrow_n` is low only while `q` is 0 and the synchronized `dn_clk` is low, with the same two-edge lag. Otherwise `borrow_n` is high.
- R7: When both synchronized strobes rise in the same system cycle, `q` holds its value.
- R8: While `rst_n` is low, `q` is 0, `carry_n` and `borrow_n` are high, and both strobes are taken as idle high.
- R9: When the `carry_n` and `borrow_n` of one stage drive the `up_clk` and `dn_clk` of a second stage, the two stages together count as one counter of twice the width, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| clr | input | 1 | Synchronous clear, active high |
| load_n | input | 1 | Synchronous parallel load, active low |
| data_in | input | WIDTH | Value to load |
| up_clk | input | 1 | Count-up strobe, counts on its rising edge |
| dn_clk | input | 1 | Count-down strobe, counts on its rising edge |
| q | output | WIDTH | Counter value |
| carry_n | output | 1 | Overflow strobe, active low |
| borrow_n | output | 1 | Underflow strobe, active low |

## Verification
Clear and load are sampled levels, so their effect is checked one clock edge after they are applied. A strobe edge passes two synchronizer flops and the edge register, so the bench checks the count three edges after it drives the edge. It checks carry or borrow two edges after the strobe falls. In the chained test, the upper stage's count is due five edges after the lower stage's strobe rises, and it is checked then. All stimulus changes on the falling clock edge, so each check lands between edges at a known position in that count.

// File: rtl/updn_pkg.sv
package updn_pkg;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_CLEAR,
    OP_LOAD,
    OP_UP,
    OP_DOWN
  } count_op_e;

  // Priority: clear, then load, then a lone strobe edge; both edges hold.
  function automatic count_op_e pick_op(input logic clr, input logic load_n,
                                        input logic up_rise, input logic dn_rise);
    if (clr)                       return OP_CLEAR;
    else if (!load_n)              return OP_LOAD;
    else if (up_rise && !dn_rise)  return OP_UP;
    else if (dn_rise && !up_rise)  return OP_DOWN;
    else                           return OP_HOLD;
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic level,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= strobe_in;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[LAST-1:0], strobe_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[LAST];

  assign level = chain[LAST];
  assign rise  = level & ~prev;

  // R1: an edge is reported for exactly one cycle
  assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/count_core.sv
module count_core
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  count_op_e        op,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] q,
  output logic             at_max,
  output logic             at_zero
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  function automatic logic [WIDTH-1:0] step(input logic [WIDTH-1:0] v,
                                            input count_op_e o,
                                            input logic [WIDTH-1:0] d);
    case (o)
      OP_CLEAR: return '0;
      OP_LOAD:  return d;
      OP_UP:    return (v == TOP) ? '0 : v + 1'b1;
      OP_DOWN:  return (v == '0) ? TOP : v - 1'b1;
      default:  return v;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= step(q, op, data_in);

  assign at_max  = (q == TOP);
  assign at_zero = (q == '0);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CLEAR |=> q == '0);
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |=> q == $past(data_in));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_HOLD |=> $stable(q));
  assert_wrap_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_UP && at_max) |=> at_zero);
  assert_wrap_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DOWN && at_zero) |=> at_max);
endmodule

// File: rtl/chain_gate.sv
module chain_gate (
  input  logic at_max,
  input  logic at_zero,
  input  logic up_level,
  input  logic dn_level,
  output logic carry_n,
  output logic borrow_n
);
  assign carry_n  = ~(at_max  & ~up_level);
  assign borrow_n = ~(at_zero & ~dn_level);
endmodule

// File: rtl/updown_strobe_counter.sv
module updown_strobe_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data_in,
  input  logic             up_clk,
  input  logic             dn_clk,
  output logic [WIDTH-1:0] q,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic      up_level, up_rise, dn_level, dn_rise;
  logic      at_max, at_zero;
  count_op_e op;

  strobe_sync #(.STAGES(SYNC_STAGES)) i_up_sync (
    .clk(clk), .rst_n(rst_n), .strobe_in(up_clk), .level(up_level), .rise(up_rise));
  strobe_sync #(.STAGES(SYNC_STAGES)) i_dn_sync (
    .clk(clk), .rst_n(rst_n), .strobe_in(dn_clk), .level(dn_level), .rise(dn_rise));

  assign op = pick_op(clr, load_n, up_rise, dn_rise);

  count_core #(.WIDTH(WIDTH)) i_core (
    .clk(clk), .rst_n(rst_n), .op(op), .data_in(data_in),
    .q(q), .at_max(at_max), .at_zero(at_zero));

  chain_gate i_gate (
    .at_max(at_max), .at_zero(at_zero), .up_level(up_level), .dn_level(dn_level),
    .carry_n(carry_n), .borrow_n(borrow_n));

  // R5 / R6: the chain outputs stay idle away from the terminal values
  assert_carry_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q != TOP) |-> carry_n);
  assert_borrow_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q != '0) |-> borrow_n);
  // R4: clear overrides load and strobes
  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> q == '0);
endmodule

// File: tb/test_updown_strobe_counter.sv
module test_updown_strobe_counter;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr = 1'b0, load_n = 1'b1;
  logic [W-1:0] data_in = '0;
  logic         up_clk = 1'b1, dn_clk = 1'b1;
  logic [W-1:0] q;
  logic         carry_n, borrow_n;
  logic         hi_clr = 1'b0;
  logic [W-1:0] hi_q;
  logic         hi_carry_n, hi_borrow_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  updown_strobe_counter #(.WIDTH(W)) i_updown_strobe_counter (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .data_in(data_in),
    .up_clk(up_clk), .dn_clk(dn_clk), .q(q), .carry_n(carry_n), .borrow_n(borrow_n));

  updown_strobe_counter #(.WIDTH(W)) i_hi (
    .clk(clk), .rst_n(rst_n), .clr(hi_clr), .load_n(1'b1), .data_in('0),
    .up_clk(carry_n), .dn_clk(borrow_n), .q(hi_q), .carry_n(hi_carry_n),
    .borrow_n(hi_borrow_n));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Strobe low for several cycles, then rise; the count is due three edges on.
  task automatic pulse_up();
    up_clk = 1'b0; ticks(4);
    up_clk = 1'b1; ticks(3);
  endtask

  task automatic pulse_dn();
    dn_clk = 1'b0; ticks(4);
    dn_clk = 1'b1; ticks(3);
  endtask

  task automatic load_value(input logic [W-1:0] v);
    data_in = v; load_n = 1'b0; ticks(1);
    load_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R8 q", int'(q), 0);
    check("R8 carry_n", int'(carry_n), 1);
    check("R8 borrow_n", int'(borrow_n), 1);
  endtask

  task automatic t_up();
    load_value(4'd5);
    check("R3 load", int'(q), 5);
    pulse_up();
    check("R1 inc", int'(q), 6);
    up_clk = 1'b0; ticks(2);
    check("R1 latency before edge", int'(q), 6);
    up_clk = 1'b1; ticks(2);
    check("R1 not yet counted", int'(q), 6);
    ticks(1);
    check("R1 counted on third edge", int'(q), 7);
  endtask

  task automatic t_carry_wrap();
    load_value(4'd15);
    up_clk = 1'b0; ticks(1);
    check("R5 carry lag", int'(carry_n), 1);
    ticks(1);
    check("R5 carry low at max", int'(carry_n), 0);
    ticks(2);
    up_clk = 1'b1; ticks(2);
    check("R5 carry released", int'(carry_n), 1);
    ticks(1);
    check("R1 wrap to 0", int'(q), 0);
  endtask

  task automatic t_down();
    load_value(4'd0);
    dn_clk = 1'b0; ticks(2);
    check("R6 borrow low at zero", int'(borrow_n), 0);
    check("R5 carry idle at zero", int'(carry_n), 1);
    ticks(2);
    dn_clk = 1'b1; ticks(3);
    check("R2 wrap to max", int'(q), 15);
    check("R6 borrow idle", int'(borrow_n), 1);
    pulse_dn();
    check("R2 dec", int'(q), 14);
  endtask

  task automatic t_priority();
    load_value(4'd9);
    load_n = 1'b0; data_in = 4'd3;
    up_clk = 1'b0; ticks(4);
    up_clk = 1'b1; ticks(4);
    check("R3 strobes ignored during load", int'(q), 3);
    clr = 1'b1; ticks(1);
    check("R4 clear over load", int'(q), 0);
    up_clk = 1'b0; ticks(3);
    up_clk = 1'b1; ticks(4);
    check("R4 clear over count", int'(q), 0);
    clr = 1'b0; load_n = 1'b1; ticks(1);
    check("R4 stays zero after clear", int'(q), 0);
  endtask

  task automatic t_both();
    load_value(4'd8);
    up_clk = 1'b0; dn_clk = 1'b0; ticks(4);
    up_clk = 1'b1; dn_clk = 1'b1; ticks(4);
    check("R7 both edges hold", int'(q), 8);
  endtask

  task automatic t_cascade();
    hi_clr = 1'b1; ticks(1); hi_clr = 1'b0;
    load_value(4'd15);
    check("R9 upper cleared", int'(hi_q), 0);
    pulse_up();
    ticks(2);
    check("R9 lower wrapped", int'(q), 0);
    check("R9 upper carried in", int'(hi_q), 1);
    pulse_dn();
    ticks(2);
    check("R9 lower borrowed", int'(q), 15);
    check("R9 upper borrowed out", int'(hi_q), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ticks(3);
    t_reset();
    rst_n = 1'b1;
    ticks(1);
    t_up();
    t_carry_wrap();
    t_down();
    t_priority();
    t_both();
    t_cascade();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule